// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This unit sits beside a 64-bit ECC-protected memory datapath and records what goes wrong on checked reads. The read checker sends one transfer per read over a valid/ready stream. Each transfer carries the address, the 64-bit data word, the check field and two error flags, one for single-bit errors and one for multi-bit errors. The unit sets sticky detect bits. It keeps the data, check field and address of the first reported error, and it raises an interrupt line for the error kinds that software has enabled. Single-bit errors are counted, and a detect bit is raised only when the count reaches a programmable threshold. This lets software choose how many corrected errors make up one interrupt.

The unit also holds the masks used for error injection. The write path passes its data and check code through the unit. While injection is enabled, the unit flips the data and check bits selected by the masks.

Software reaches every register over a plain 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the word address.

The check stream has no back-pressure in practice. `chk_ready` rises in the first cycle after reset and then stays high. A producer may hold `chk_valid` for as many cycles as it likes, and each cycle with both signals high counts as one transfer. Error flags are ignored while `chk_valid` is low.

Top module: `mecc_err_unit`

## Requirements
- R1: After reset, every register reads 0 except the single-bit management register (word 3), which reads 0x00010000 (threshold 1, count 0). `irq` is 0.
- R2: An accepted transfer with `chk_mbe` high sets detect bit 1 (word 0) on the next clock, unless disable bit 1 is set.
- R3: An accepted transfer with `chk_sbe` high and `chk_mbe` low advances the count in bits 7:0 of word 3. When the advanced count reaches or passes the threshold in bits 23:16, detect bit 0 is set and the count returns to 0. A threshold of 0 acts like 1. A transfer that carries both flags is treated only as a multi-bit error.
- R4: When an event sets a detect bit while both detect bits are clear, the capture registers load. Word 4 takes data bits 63:32, word 5 data bits 31:0, word 6 the check field, word 7 address bits 31:0 and word 8 the upper address bits. Further events do not change them while either detect bit is set. Writes to words 4 to 8 are ignored.
- R5: Writing ones to word 0 clears the matching detect bits. When an event sets a bit in the same cycle as a write clears it, the bit ends up set.
- R6: Disable register (word 1) bit 0 suppresses single-bit events, including counting. Bit 1 suppresses multi-bit events.
- R7: `irq` is high exactly when a detect bit is set together with its enable in word 2 (bit 0 single-bit, bit 1 multi-bit).
- R8: Word 12 bit 0 selects a 32-bit data bus. With it set, word 6 captures `chk_code[15:0]`. With it clear, word 6 holds only `chk_code[7:0]` and its bits 15:8 read 0.
- R9: The injection registers read back the last full 32-bit value written: word 9 is the upper data mask, word 10 the lower data mask and word 11 the injection control.
- R10: While word 11 bit 8 is set, `wr_data_out` equals `wr_data_in` XOR {word 9, word 10}, and `wr_code_out` equals `wr_code_in` XOR word 11 bits 7:0. While bit 8 is clear, both pass through unchanged.
- R11: `chk_ready` is high from the first cycle after reset onward. Flags presented while `chk_valid` is low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid | input | 1 | Checked-read transfer valid |
| chk_ready | output | 1 | Unit accepts transfers |
| chk_addr | input | ADDR_W (40) | Address of the checked read |
| chk_data | input | DATA_W (64) | Data as read |
| chk_code | input | CODE_W (16) | Check field as read |
| chk_sbe | input | 1 | Single-bit error flag |
| chk_mbe | input | 1 | Multi-bit error flag |
| wr_data_in | input | DATA_W (64) | Write-path data before injection |
| wr_code_in | input | CODE_W/2 (8) | Write-path check code before injection |
| wr_data_out | output | DATA_W (64) | Write-path data after injection |
| wr_code_out | output | CODE_W/2 (8) | Write-path check code after injection |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (4) | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Error interrupt |

## Verification
The hardest case to reach is a single-bit error that completes the threshold while a capture is already held, or while software is clearing detect bits in the same cycle. Only the transfer that completes the count may capture, and a clear that lands in the same cycle as a set must lose. The bench gets there in steps. It programs a threshold of 3 and checks the count after each sub-threshold transfer. It then sends the third error with data that differs from the first two. In a separate step it drives a multi-bit transfer in the same clock as a write-one-to-clear.

// File: rtl/mecc_pkg.sv
package mecc_pkg;
  // register word addresses
  localparam logic [3:0] RA_DET     = 4'd0;
  localparam logic [3:0] RA_DIS     = 4'd1;
  localparam logic [3:0] RA_IEN     = 4'd2;
  localparam logic [3:0] RA_SBEM    = 4'd3;
  localparam logic [3:0] RA_CAP_HI  = 4'd4;
  localparam logic [3:0] RA_CAP_LO  = 4'd5;
  localparam logic [3:0] RA_CAP_CD  = 4'd6;
  localparam logic [3:0] RA_CAP_AL  = 4'd7;
  localparam logic [3:0] RA_CAP_AX  = 4'd8;
  localparam logic [3:0] RA_INJ_HI  = 4'd9;
  localparam logic [3:0] RA_INJ_LO  = 4'd10;
  localparam logic [3:0] RA_INJ_CTL = 4'd11;
  localparam logic [3:0] RA_CFG     = 4'd12;

  // bit positions shared by detect, disable and enable registers
  localparam int EB_SBE = 0;
  localparam int EB_MBE = 1;
  localparam int EB_N   = 2;

  localparam int INJ_EN_BIT = 8;
  localparam int CNT_W      = 8;
  localparam int THR_LSB    = 16;
  localparam logic [CNT_W-1:0] THR_RESET = 8'd1;

  typedef logic [EB_N-1:0] err_vec_t;
endpackage

// File: rtl/mecc_sbe_counter.sv
module mecc_sbe_counter
  import mecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             load,
  input  logic [CNT_W-1:0] thr_in,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W:0] cnt_next;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  // threshold 0 is met by any advanced count, so it behaves like 1
  assign hit = inc && (cnt_next >= {1'b0, thr});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr <= THR_RESET;
      cnt <= '0;
    end else if (load) begin
      thr <= thr_in;
      cnt <= cnt_in;
    end else if (inc) begin
      cnt <= hit ? '0 : cnt_next[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/mecc_capture.sv
module mecc_capture #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] addr,
  output logic [31:0]       cap_hi,
  output logic [31:0]       cap_lo,
  output logic [31:0]       cap_code,
  output logic [31:0]       cap_addr_lo,
  output logic [31:0]       cap_addr_ext
);
  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = ADDR_W - 32;

  logic [DATA_W-1:0] data_q;
  logic [CODE_W-1:0] code_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      code_q <= '0;
      addr_q <= '0;
    end else if (load) begin
      data_q <= data;
      code_q <= code;
      addr_q <= addr;
    end
  end

  assign cap_hi      = data_q[DATA_W-1:HALF_W];
  assign cap_lo      = data_q[HALF_W-1:0];
  assign cap_code    = {{(32-CODE_W){1'b0}}, code_q};
  assign cap_addr_lo = addr_q[31:0];

  generate
    if (EXT_W > 0) begin : g_ext
      assign cap_addr_ext = {{(32-EXT_W){1'b0}}, addr_q[ADDR_W-1:32]};
    end else begin : g_noext
      assign cap_addr_ext = '0;
    end
  endgenerate
endmodule

// File: rtl/mecc_inject.sv
module mecc_inject #(
  parameter int DATA_W = 64,
  parameter int ICODE_W = 8
) (
  input  logic               en,
  input  logic [DATA_W-1:0]  mask,
  input  logic [ICODE_W-1:0] code_mask,
  input  logic [DATA_W-1:0]  data_in,
  input  logic [ICODE_W-1:0] code_in,
  output logic [DATA_W-1:0]  data_out,
  output logic [ICODE_W-1:0] code_out
);
  localparam int LANE_W = 32;
  localparam int NLANE  = DATA_W / LANE_W;

  generate
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      assign data_out[l*LANE_W +: LANE_W] =
        data_in[l*LANE_W +: LANE_W] ^ (en ? mask[l*LANE_W +: LANE_W] : '0);
    end
  endgenerate

  assign code_out = code_in ^ (en ? code_mask : '0);
endmodule

// File: rtl/mecc_err_unit.sv
module mecc_err_unit
  import mecc_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int CODE_W = 16,
  parameter int REG_AW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chk_valid,
  output logic                  chk_ready,
  input  logic [ADDR_W-1:0]     chk_addr,
  input  logic [DATA_W-1:0]     chk_data,
  input  logic [CODE_W-1:0]     chk_code,
  input  logic                  chk_sbe,
  input  logic                  chk_mbe,
  input  logic [DATA_W-1:0]     wr_data_in,
  input  logic [CODE_W/2-1:0]   wr_code_in,
  output logic [DATA_W-1:0]     wr_data_out,
  output logic [CODE_W/2-1:0]   wr_code_out,
  input  logic                  reg_wr,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  irq
);
  localparam int WCODE_W = CODE_W / 2;

  logic       rdy_q;
  err_vec_t   det_q, dis_q, ien_q;
  logic       cfg_narrow_q;
  logic [31:0] inj_hi_q, inj_lo_q, inj_ctl_q;

  logic       accept, sbe_ev, mbe_ev, sbe_hit, cap_load;
  err_vec_t   set_vec, clr_vec;
  logic [CODE_W-1:0] code_sel;
  logic [CNT_W-1:0]  sbe_thr, sbe_cnt;
  logic [31:0] cap_hi, cap_lo, cap_code, cap_addr_lo, cap_addr_ext;

  logic wr_det, wr_dis, wr_ien, wr_sbem, wr_ihi, wr_ilo, wr_ictl, wr_cfg;

  assign wr_det  = reg_wr && (reg_addr == REG_AW'(RA_DET));
  assign wr_dis  = reg_wr && (reg_addr == REG_AW'(RA_DIS));
  assign wr_ien  = reg_wr && (reg_addr == REG_AW'(RA_IEN));
  assign wr_sbem = reg_wr && (reg_addr == REG_AW'(RA_SBEM));
  assign wr_ihi  = reg_wr && (reg_addr == REG_AW'(RA_INJ_HI));
  assign wr_ilo  = reg_wr && (reg_addr == REG_AW'(RA_INJ_LO));
  assign wr_ictl = reg_wr && (reg_addr == REG_AW'(RA_INJ_CTL));
  assign wr_cfg  = reg_wr && (reg_addr == REG_AW'(RA_CFG));

  // stream side: no back-pressure once out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign chk_ready = rdy_q;

  assign accept = chk_valid && rdy_q;
  assign mbe_ev = accept && chk_mbe && !dis_q[EB_MBE];
  assign sbe_ev = accept && chk_sbe && !chk_mbe && !dis_q[EB_SBE];

  mecc_sbe_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (sbe_ev),
    .load   (wr_sbem),
    .thr_in (reg_wdata[THR_LSB +: CNT_W]),
    .cnt_in (reg_wdata[CNT_W-1:0]),
    .thr    (sbe_thr),
    .cnt    (sbe_cnt),
    .hit    (sbe_hit)
  );

  always_comb begin
    set_vec = '0;
    set_vec[EB_SBE] = sbe_hit;
    set_vec[EB_MBE] = mbe_ev;
  end
  assign clr_vec  = wr_det ? reg_wdata[EB_N-1:0] : '0;
  assign cap_load = (|set_vec) && (det_q == '0);

  // set wins over a clear landing in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) det_q <= '0;
    else        det_q <= (det_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q        <= '0;
      ien_q        <= '0;
      cfg_narrow_q <= 1'b0;
      inj_hi_q     <= '0;
      inj_lo_q     <= '0;
      inj_ctl_q    <= '0;
    end else begin
      if (wr_dis)  dis_q        <= reg_wdata[EB_N-1:0];
      if (wr_ien)  ien_q        <= reg_wdata[EB_N-1:0];
      if (wr_cfg)  cfg_narrow_q <= reg_wdata[0];
      if (wr_ihi)  inj_hi_q     <= reg_wdata;
      if (wr_ilo)  inj_lo_q     <= reg_wdata;
      if (wr_ictl) inj_ctl_q    <= reg_wdata;
    end
  end

  assign code_sel = cfg_narrow_q ? chk_code
                                 : {{(CODE_W-WCODE_W){1'b0}}, chk_code[WCODE_W-1:0]};

  mecc_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (cap_load),
    .data         (chk_data),
    .code         (code_sel),
    .addr         (chk_addr),
    .cap_hi       (cap_hi),
    .cap_lo       (cap_lo),
    .cap_code     (cap_code),
    .cap_addr_lo  (cap_addr_lo),
    .cap_addr_ext (cap_addr_ext)
  );

  mecc_inject #(.DATA_W(DATA_W), .ICODE_W(WCODE_W)) u_inj (
    .en        (inj_ctl_q[INJ_EN_BIT]),
    .mask      ({inj_hi_q, inj_lo_q}),
    .code_mask (inj_ctl_q[WCODE_W-1:0]),
    .data_in   (wr_data_in),
    .code_in   (wr_code_in),
    .data_out  (wr_data_out),
    .code_out  (wr_code_out)
  );

  assign irq = |(det_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_AW'(RA_DET):     reg_rdata[EB_N-1:0] = det_q;
      REG_AW'(RA_DIS):     reg_rdata[EB_N-1:0] = dis_q;
      REG_AW'(RA_IEN):     reg_rdata[EB_N-1:0] = ien_q;
      REG_AW'(RA_SBEM): begin
        reg_rdata[THR_LSB +: CNT_W] = sbe_thr;
        reg_rdata[CNT_W-1:0]        = sbe_cnt;
      end
      REG_AW'(RA_CAP_HI):  reg_rdata = cap_hi;
      REG_AW'(RA_CAP_LO):  reg_rdata = cap_lo;
      REG_AW'(RA_CAP_CD):  reg_rdata = cap_code;
      REG_AW'(RA_CAP_AL):  reg_rdata = cap_addr_lo;
      REG_AW'(RA_CAP_AX):  reg_rdata = cap_addr_ext;
      REG_AW'(RA_INJ_HI):  reg_rdata = inj_hi_q;
      REG_AW'(RA_INJ_LO):  reg_rdata = inj_lo_q;
      REG_AW'(RA_INJ_CTL): reg_rdata = inj_ctl_q;
      REG_AW'(RA_CFG):     reg_rdata[0] = cfg_narrow_q;
      default:             reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mecc_err_unit_chk.sv
module mecc_err_unit_chk
  import mecc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chk_valid,
  input logic              chk_ready,
  input logic              chk_sbe,
  input logic              chk_mbe,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq,
  input logic [1:0]        det_q,
  input logic [1:0]        dis_q,
  input logic [1:0]        ien_q,
  input logic [7:0]        sbe_thr,
  input logic [7:0]        sbe_cnt,
  input logic [31:0]       cap_hi,
  input logic [31:0]       cap_lo,
  input logic [31:0]       cap_code,
  input logic [31:0]       inj_ctl_q,
  input logic [DATA_W-1:0] wr_data_in,
  input logic [DATA_W-1:0] wr_data_out
);
  logic acc, wr_det, wr_ien, wr_sbem;
  assign acc     = chk_valid && chk_ready;
  assign wr_det  = reg_wr && (reg_addr == REG_AW'(RA_DET));
  assign wr_ien  = reg_wr && (reg_addr == REG_AW'(RA_IEN));
  assign wr_sbem = reg_wr && (reg_addr == REG_AW'(RA_SBEM));

  a_r2_mbe_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && chk_mbe && !dis_q[EB_MBE]) |=> det_q[EB_MBE]);

  a_r3_threshold_one: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && chk_sbe && !chk_mbe && !dis_q[EB_SBE] && sbe_thr == 8'd1 && !wr_sbem)
      |=> (det_q[EB_SBE] && sbe_cnt == 8'd0));

  a_r4_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (det_q != 2'b00) |=> ($stable(cap_hi) && $stable(cap_lo) && $stable(cap_code)));

  a_r5_w1c_mbe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_det && reg_wdata[EB_MBE] && !(acc && chk_mbe && !dis_q[EB_MBE]))
      |=> !det_q[EB_MBE]);

  a_r7_irq_on_mbe: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && chk_mbe && !dis_q[EB_MBE] && ien_q[EB_MBE] && !wr_ien) |=> irq);

  a_r10_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_ctl_q[INJ_EN_BIT] |-> (wr_data_out == wr_data_in));
endmodule

bind mecc_err_unit mecc_err_unit_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chk_valid   (chk_valid),
  .chk_ready   (chk_ready),
  .chk_sbe     (chk_sbe),
  .chk_mbe     (chk_mbe),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .irq         (irq),
  .det_q       (det_q),
  .dis_q       (dis_q),
  .ien_q       (ien_q),
  .sbe_thr     (sbe_thr),
  .sbe_cnt     (sbe_cnt),
  .cap_hi      (cap_hi),
  .cap_lo      (cap_lo),
  .cap_code    (cap_code),
  .inj_ctl_q   (inj_ctl_q),
  .wr_data_in  (wr_data_in),
  .wr_data_out (wr_data_out)
);

// File: tb/mecc_err_unit_bench.sv
module mecc_err_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid = 1'b0;
  logic        chk_ready;
  logic [39:0] chk_addr = '0;
  logic [63:0] chk_data = '0;
  logic [15:0] chk_code = '0;
  logic        chk_sbe = 1'b0;
  logic        chk_mbe = 1'b0;
  logic [63:0] wr_data_in = '0;
  logic [7:0]  wr_code_in = '0;
  logic [63:0] wr_data_out;
  logic [7:0]  wr_code_out;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mecc_err_unit u_mecc_err_unit (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  task automatic send(input logic v, input logic s, input logic m, input logic [63:0] d,
                      input logic [15:0] c, input logic [39:0] a);
    @(negedge clk);
    chk_valid = v; chk_sbe = s; chk_mbe = m; chk_data = d; chk_code = c; chk_addr = a;
    @(negedge clk);
    chk_valid = 1'b0; chk_sbe = 1'b0; chk_mbe = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R11 ready", {63'h0, chk_ready}, 64'h1);
    check("R1 irq", {63'h0, irq}, 64'h0);
    rd_check("R1 det", 4'd0, 32'h0);
    rd_check("R1 sbem", 4'd3, 32'h0001_0000);
    rd_check("R1 cap", 4'd4, 32'h0);
    rd_check("R1 inj", 4'd11, 32'h0);
  endtask

  task automatic t_mbe_capture;
    send(1, 0, 1, 64'hDEADBEEF_01234567, 16'hA55A, 40'h12_3456789A);
    rd_check("R2 det", 4'd0, 32'h2);
    rd_check("R4 hi", 4'd4, 32'hDEADBEEF);
    rd_check("R4 lo", 4'd5, 32'h01234567);
    rd_check("R8 wide code", 4'd6, 32'h5A);
    rd_check("R4 addr", 4'd7, 32'h3456789A);
    rd_check("R4 ext", 4'd8, 32'h12);
    send(1, 0, 1, 64'h1111_2222_3333_4444, 16'h0077, 40'h00_00000010);
    rd_check("R4 hold hi", 4'd4, 32'hDEADBEEF);
    rd_check("R4 hold addr", 4'd7, 32'h3456789A);
    wr(4'd4, 32'h0);
    rd_check("R4 readonly", 4'd4, 32'hDEADBEEF);
    wr(4'd0, 32'h3);
    rd_check("R5 clear", 4'd0, 32'h0);
    send(1, 0, 1, 64'hCAFE0000_0000BEEF, 16'h0011, 40'h00_00000020);
    rd_check("R4 recapture", 4'd5, 32'h0000BEEF);
    wr(4'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_sbe_threshold;
    wr(4'd3, 32'h0003_0000);
    send(1, 1, 0, 64'h1, 16'h0, 40'h1);
    rd_check("R3 count1", 4'd3, 32'h0003_0001);
    send(1, 1, 0, 64'h2, 16'h0, 40'h2);
    rd_check("R3 count2", 4'd3, 32'h0003_0002);
    rd_check("R3 no det", 4'd0, 32'h0);
    send(1, 1, 0, 64'h3, 16'h0, 40'h3);
    rd_check("R3 det", 4'd0, 32'h1);
    rd_check("R3 count wrap", 4'd3, 32'h0003_0000);
    rd_check("R4 sbe capture", 4'd5, 32'h3);
    wr(4'd0, 32'h1);
    send(1, 1, 1, 64'h4, 16'h0, 40'h4);
    rd_check("R3 both flags", 4'd0, 32'h2);
    rd_check("R3 both no count", 4'd3, 32'h0003_0000);
    wr(4'd0, 32'h3);
    wr(4'd3, 32'h0);
    send(1, 1, 0, 64'h5, 16'h0, 40'h5);
    rd_check("R3 thr zero", 4'd0, 32'h1);
    wr(4'd0, 32'h3);
    wr(4'd3, 32'h0001_0000);
  endtask

  task automatic t_disable;
    wr(4'd1, 32'h1);
    send(1, 1, 0, 64'h6, 16'h0, 40'h6);
    rd_check("R6 sbe off", 4'd0, 32'h0);
    rd_check("R6 no count", 4'd3, 32'h0001_0000);
    wr(4'd1, 32'h2);
    send(1, 0, 1, 64'h7, 16'h0, 40'h7);
    rd_check("R6 mbe off", 4'd0, 32'h0);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_irq;
    wr(4'd2, 32'h2);
    send(1, 1, 0, 64'h8, 16'h0, 40'h8);
    check("R7 sbe masked", {63'h0, irq}, 64'h0);
    send(1, 0, 1, 64'h9, 16'h0, 40'h9);
    check("R7 mbe irq", {63'h0, irq}, 64'h1);
    wr(4'd0, 32'h2);
    check("R7 cleared", {63'h0, irq}, 64'h0);
    wr(4'd2, 32'h1);
    check("R7 sbe irq", {63'h0, irq}, 64'h1);
    wr(4'd2, 32'h0);
    check("R7 disabled", {63'h0, irq}, 64'h0);
    wr(4'd0, 32'h3);
  endtask

  task automatic t_narrow;
    wr(4'd12, 32'h1);
    send(1, 0, 1, 64'hA, 16'hBEEF, 40'hA);
    rd_check("R8 narrow code", 4'd6, 32'hBEEF);
    wr(4'd0, 32'h3);
    wr(4'd12, 32'h0);
  endtask

  task automatic t_race;
    @(negedge clk);
    chk_valid = 1; chk_mbe = 1; chk_data = 64'hB; chk_code = 16'h0;
    reg_wr = 1; reg_addr = 4'd0; reg_wdata = 32'h2;
    @(negedge clk);
    chk_valid = 0; chk_mbe = 0; reg_wr = 0;
    rd_check("R5 set wins", 4'd0, 32'h2);
    wr(4'd0, 32'h3);
  endtask

  task automatic t_idle;
    send(0, 1, 1, 64'hC, 16'h0, 40'hC);
    rd_check("R11 idle det", 4'd0, 32'h0);
    rd_check("R11 idle count", 4'd3, 32'h0001_0000);
  endtask

  task automatic t_inject;
    wr(4'd9, 32'hF000_0001);
    wr(4'd10, 32'h8000_0000);
    wr(4'd11, 32'h0000_01A5);
    rd_check("R9 hi", 4'd9, 32'hF000_0001);
    rd_check("R9 lo", 4'd10, 32'h8000_0000);
    rd_check("R9 ctl", 4'd11, 32'h0000_01A5);
    wr_data_in = 64'h0F0F_0F0F_0000_FFFF; wr_code_in = 8'h0F;
    #1;
    check("R10 data", wr_data_out, 64'hFF0F_0F0E_8000_FFFF);
    check("R10 code", {56'h0, wr_code_out}, 64'hAA);
    wr(4'd11, 32'h0000_00A5);
    #1;
    check("R10 pass data", wr_data_out, 64'h0F0F_0F0F_0000_FFFF);
    check("R10 pass code", {56'h0, wr_code_out}, 64'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mbe_capture();
    t_sbe_threshold();
    t_disable();
    t_irq();
    t_narrow();
    t_race();
    t_idle();
    t_inject();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule